// File: doc/BRIEF.md
# General-Purpose Register File with Unified Data-Space Map

This block holds the working registers of a small 8-bit RISC core. It has two combinational read ports and one write port, so an ALU can fetch two operands and store its result within one clock. The top six registers are joined into three 16-bit address pointers. The core uses these pointers for indirect data accesses. One of them is also sent out on its own as the address for reading constants from program memory. Any of the three pointers can be incremented or decremented as a full 16-bit value in a single cycle.

A second access path uses 8-bit data-space addresses. The bottom of the map reaches the registers themselves. Above them is a 64-location window, which the block forwards to an external peripheral bus. Above that is an on-block 128-byte data SRAM. Addresses beyond the SRAM read as zero and cannot be written. All regions are sized by parameters, and their base addresses are derived from those sizes.

Top module: `gpr_dataspace`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register and every SRAM byte is cleared to 0x00, so all pointers read 0x0000 afterwards.
- R2: `rd_a_data` and `rd_b_data` show, combinationally, the registers selected by `rd_a_sel` and `rd_b_sel`. A register written in a cycle still reads its old value in that cycle and reads the new value from the next cycle.
- R3: When `alu_we` is high, register `alu_wsel` takes `alu_wdata` at the clock edge.
- R4: `ptr_x` is {r27, r26}, `ptr_y` is {r29, r28} and `ptr_z` is {r31, r30}, each written as high byte then low byte. `const_addr` always equals `ptr_z`.
- R5: `ptr_sel` chooses the pointer (0 = X, 1 = Y, 2 = Z, 3 = none). `ptr_op` chooses the action (1 = add one, 2 = subtract one, 0 or 3 = none). The update acts on the whole 16-bit pair in one cycle: a carry or borrow passes from the low byte into the high byte, and the value wraps at 16 bits.
- R6: Data addresses 0x00 to 0x1F read and write registers 0 to 31.
- R7: Data addresses 0x20 to 0x5F reach the peripheral bus at `io_addr` = address − 0x20. `io_we` follows `ds_we` and `io_re` follows `ds_re` only inside this window. `ds_rdata` returns `io_rdata`, and `io_wdata` carries `ds_wdata`.
- R8: Data addresses 0x60 to 0xDF read and write SRAM byte address − 0x60. A written byte can be read back from the next cycle.
- R9: Data addresses 0xE0 to 0xFF read as 0x00. A write to them changes no register and no SRAM byte, and raises no peripheral strobe. `ds_rdata` is 0x00 whenever `ds_re` is low.
- R10: When writes to one register collide in a cycle, the ALU write wins over a pointer update, and a pointer update wins over a data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_sel | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| alu_we | input | 1 | ALU result write enable |
| alu_wsel | input | 5 | ALU result register index |
| alu_wdata | input | 8 | ALU result value |
| ptr_sel | input | 2 | Pointer to update: 0 X, 1 Y, 2 Z, 3 none |
| ptr_op | input | 2 | Pointer action: 1 add one, 2 subtract one, else none |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |
| const_addr | output | 16 | Constant-lookup address (copy of Z) |
| ds_re | input | 1 | Data-space read request |
| ds_we | input | 1 | Data-space write request |
| ds_addr | input | 8 | Data-space address |
| ds_wdata | input | 8 | Data-space write value |
| ds_rdata | output | 8 | Data-space read value |
| io_re | output | 1 | Peripheral read strobe |
| io_we | output | 1 | Peripheral write strobe |
| io_addr | output | 6 | Peripheral location |
| io_wdata | output | 8 | Peripheral write value |
| io_rdata | input | 8 | Peripheral read value |

## Verification
The bench builds the block with its default parameters: 32 registers, a 64-location peripheral window and 128 SRAM bytes. With these values the derived bases are 0x20 and 0x60 and the end of the SRAM is 0xE0, so the 8-bit address space is fully covered and the unmapped tail 0xE0–0xFF can be exercised. Because the pointer registers are the top six entries, directed writes can collide with pointer updates, and so can random ALU and data-space writes that are biased toward indices 26–31. This exercises carry and borrow across the byte boundary and every level of the write priority.

// File: rtl/gpr_pkg.sv
// Package: shared encodings for the register file and its data-space decode.
// Assumes: 2-bit pointer select and pointer action codes as listed in the brief.
package gpr_pkg;
    typedef enum logic [1:0] {PSEL_X = 2'd0, PSEL_Y = 2'd1, PSEL_Z = 2'd2, PSEL_NONE = 2'd3} ptr_sel_e;
    typedef enum logic [1:0] {POP_NONE = 2'd0, POP_INC = 2'd1, POP_DEC = 2'd2, POP_RSV = 2'd3} ptr_op_e;
    typedef enum logic [1:0] {RGN_REG, RGN_IO, RGN_RAM, RGN_NONE} ds_region_e;
endpackage

// File: rtl/gpr_array.sv
// Module: gpr_array
// Register array with two operand read ports, an ALU write port, a data-space
// read/write port and an in-place 16-bit pointer update on the top six entries.
// Assumes: NREG >= 6; write priority is ALU, then pointer update, then data space.
module gpr_array
    import gpr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG),
    localparam int PW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic          alu_we,
    input  logic [IW-1:0] alu_idx,
    input  logic [DW-1:0] alu_d,
    input  logic          ds_we,
    input  logic [IW-1:0] ds_idx,
    input  logic [DW-1:0] ds_d,
    output logic [DW-1:0] ds_q,
    input  logic [1:0]    psel,
    input  logic [1:0]    pop,
    output logic [PW-1:0] px,
    output logic [PW-1:0] py,
    output logic [PW-1:0] pz
);
    localparam int XLO = NREG - 6;

    logic [DW-1:0] mem [NREG];
    logic [DW-1:0] nxt [NREG];
    logic [IW-1:0] lo_idx;
    logic [PW-1:0] pair_old;
    logic [PW-1:0] pair_new;
    logic          p_act;

    // Read ports: combinational, so a same-cycle write is not yet visible.
    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
    assign ds_q    = mem[ds_idx];

    // Pointer views of the top six registers.
    assign px = {mem[XLO+1], mem[XLO]};
    assign py = {mem[XLO+3], mem[XLO+2]};
    assign pz = {mem[XLO+5], mem[XLO+4]};

    // Pointer update: select the pair and form its incremented or decremented value.
    always_comb begin
        lo_idx   = IW'(XLO + 2 * int'(psel));
        pair_old = {mem[lo_idx + IW'(1)], mem[lo_idx]};
        p_act    = (ptr_sel_e'(psel) != PSEL_NONE) &&
                   ((ptr_op_e'(pop) == POP_INC) || (ptr_op_e'(pop) == POP_DEC));
        pair_new = (ptr_op_e'(pop) == POP_INC) ? pair_old + PW'(1) : pair_old - PW'(1);
    end

    // Next-state merge, lowest priority first so later writes win.
    always_comb begin
        nxt = mem;
        if (ds_we) nxt[ds_idx] = ds_d;
        if (p_act) begin
            nxt[lo_idx]          = pair_new[DW-1:0];
            nxt[lo_idx + IW'(1)] = pair_new[PW-1:DW];
        end
        if (alu_we) nxt[alu_idx] = alu_d;
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= '{default: '0};
        else        mem <= nxt;
    end

    // R3
    alu_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_we |=> (mem[$past(alu_idx)] == $past(alu_d)));

    // R10
    alu_over_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && ds_we && alu_idx == ds_idx) |=> (mem[$past(alu_idx)] == $past(alu_d)));

    // R5
    x_postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel == 2'd0 && pop == 2'd1 && !alu_we) |=> (px == $past(px) + PW'(1)));

    // R5
    z_predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel == 2'd2 && pop == 2'd2 && !alu_we) |=> (pz == $past(pz) - PW'(1)));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (px == '0 && py == '0 && pz == '0));
endmodule

// File: rtl/ds_decode.sv
// Module: ds_decode
// Splits a data-space address into register, peripheral-window, SRAM or
// unmapped regions and produces the per-region strobes and local offsets.
// Assumes: regions are stacked registers, window, SRAM from address zero upward.
module ds_decode
    import gpr_pkg::*;
#(
    parameter int AW         = 8,
    parameter int NREG       = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int IW        = $clog2(NREG),
    localparam int IOW       = $clog2(IO_DEPTH),
    localparam int SW        = $clog2(SRAM_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           re,
    input  logic           we,
    output ds_region_e     rgn,
    output logic           reg_we,
    output logic [IW-1:0]  reg_idx,
    output logic           io_re,
    output logic           io_we,
    output logic [IOW-1:0] io_off,
    output logic           ram_we,
    output logic [SW-1:0]  ram_idx
);
    localparam int IO_BASE  = NREG;
    localparam int RAM_BASE = IO_BASE + IO_DEPTH;
    localparam int RAM_END  = RAM_BASE + SRAM_DEPTH;

    logic [AW-1:0] io_rel;
    logic [AW-1:0] ram_rel;

    // Region classification by address range.
    always_comb begin
        if (int'(addr) < IO_BASE)       rgn = RGN_REG;
        else if (int'(addr) < RAM_BASE) rgn = RGN_IO;
        else if (int'(addr) < RAM_END)  rgn = RGN_RAM;
        else                            rgn = RGN_NONE;
    end

    // Offsets within each region and qualified strobes.
    always_comb begin
        io_rel  = addr - AW'(IO_BASE);
        ram_rel = addr - AW'(RAM_BASE);
        reg_idx = addr[IW-1:0];
        io_off  = io_rel[IOW-1:0];
        ram_idx = ram_rel[SW-1:0];
        reg_we  = we && (rgn == RGN_REG);
        io_we   = we && (rgn == RGN_IO);
        io_re   = re && (rgn == RGN_IO);
        ram_we  = we && (rgn == RGN_RAM);
    end

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, io_we, ram_we}));
endmodule

// File: rtl/ds_sram.sv
// Module: ds_sram
// Byte-wide data SRAM with combinational read and synchronous write.
// Assumes: contents are cleared by reset so reads are defined from the start.
module ds_sram #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] idx,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [DEPTH];

    // Read path.
    assign rd = mem[idx];

    // Write path with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)  mem <= '{default: '0};
        else if (we) mem[idx] <= wd;
    end

    // R8
    ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wd)));
endmodule

// File: rtl/gpr_dataspace.sv
// Module: gpr_dataspace (top)
// Register file with operand ports, pointer outputs and update, plus a unified
// data-space port covering registers, a peripheral window and a data SRAM.
// Assumes: the caller holds ds_re/ds_we low when no access is wanted.
module gpr_dataspace
    import gpr_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 8,
    parameter int NREG       = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int IW        = $clog2(NREG),
    localparam int IOW       = $clog2(IO_DEPTH),
    localparam int SW        = $clog2(SRAM_DEPTH),
    localparam int PW        = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  rd_a_sel,
    output logic [DW-1:0]  rd_a_data,
    input  logic [IW-1:0]  rd_b_sel,
    output logic [DW-1:0]  rd_b_data,
    input  logic           alu_we,
    input  logic [IW-1:0]  alu_wsel,
    input  logic [DW-1:0]  alu_wdata,
    input  logic [1:0]     ptr_sel,
    input  logic [1:0]     ptr_op,
    output logic [PW-1:0]  ptr_x,
    output logic [PW-1:0]  ptr_y,
    output logic [PW-1:0]  ptr_z,
    output logic [PW-1:0]  const_addr,
    input  logic           ds_re,
    input  logic           ds_we,
    input  logic [AW-1:0]  ds_addr,
    input  logic [DW-1:0]  ds_wdata,
    output logic [DW-1:0]  ds_rdata,
    output logic           io_re,
    output logic           io_we,
    output logic [IOW-1:0] io_addr,
    output logic [DW-1:0]  io_wdata,
    input  logic [DW-1:0]  io_rdata
);
    localparam int RAM_END = NREG + IO_DEPTH + SRAM_DEPTH;

    ds_region_e     rgn;
    logic           reg_we, ram_we;
    logic [IW-1:0]  reg_idx;
    logic [SW-1:0]  ram_idx;
    logic [DW-1:0]  reg_q, ram_q;

    ds_decode #(.AW(AW), .NREG(NREG), .IO_DEPTH(IO_DEPTH), .SRAM_DEPTH(SRAM_DEPTH)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(ds_addr), .re(ds_re), .we(ds_we), .rgn(rgn),
        .reg_we(reg_we), .reg_idx(reg_idx), .io_re(io_re), .io_we(io_we),
        .io_off(io_addr), .ram_we(ram_we), .ram_idx(ram_idx)
    );

    gpr_array #(.DW(DW), .NREG(NREG)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(rd_a_sel), .ra_data(rd_a_data), .rb_idx(rd_b_sel), .rb_data(rd_b_data),
        .alu_we(alu_we), .alu_idx(alu_wsel), .alu_d(alu_wdata),
        .ds_we(reg_we), .ds_idx(reg_idx), .ds_d(ds_wdata), .ds_q(reg_q),
        .psel(ptr_sel), .pop(ptr_op), .px(ptr_x), .py(ptr_y), .pz(ptr_z)
    );

    ds_sram #(.DW(DW), .DEPTH(SRAM_DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx), .wd(ds_wdata), .rd(ram_q)
    );

    assign const_addr = ptr_z;
    assign io_wdata   = ds_wdata;

    // Read-data steering by region; idle or unmapped reads give zero.
    always_comb begin
        ds_rdata = '0;
        if (ds_re) begin
            unique case (rgn)
                RGN_REG: ds_rdata = reg_q;
                RGN_IO:  ds_rdata = io_rdata;
                RGN_RAM: ds_rdata = ram_q;
                default: ds_rdata = '0;
            endcase
        end
    end

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_re && int'(ds_addr) >= RAM_END) |-> (ds_rdata == '0 && !io_re));

    // R7
    io_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_we |-> (ds_we && io_wdata == ds_wdata));
endmodule

// File: tb/sim_gpr_dataspace.sv
module sim_gpr_dataspace;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_sel, rd_b_sel, alu_wsel;
    logic [7:0]  rd_a_data, rd_b_data, alu_wdata, ds_wdata, ds_rdata, io_wdata, io_rdata;
    logic        alu_we, ds_re, ds_we, io_re, io_we;
    logic [1:0]  ptr_sel, ptr_op;
    logic [15:0] ptr_x, ptr_y, ptr_z, const_addr;
    logic [7:0]  ds_addr;
    logic [5:0]  io_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] m_reg [32];
    logic [7:0] m_ram [128];
    logic [7:0] m_io  [64];

    always #10 clk = ~clk;

    gpr_dataspace u0 (
        .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .alu_we(alu_we), .alu_wsel(alu_wsel),
        .alu_wdata(alu_wdata), .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_x(ptr_x),
        .ptr_y(ptr_y), .ptr_z(ptr_z), .const_addr(const_addr), .ds_re(ds_re),
        .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .io_re(io_re), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata)
    );

    // Behavioural peripheral: its contents are the model's window.
    assign io_rdata = m_io[io_addr];

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mptr(int lo);
        return {m_reg[lo+1], m_reg[lo]};
    endfunction

    // Compare every output against the model, then advance the model by one edge.
    task automatic cyc();
        int a;
        logic [7:0] exp_rd;
        logic [7:0] nreg [32];
        #1;
        a = int'(ds_addr);
        chk("R2 R3 R6 R10 port A", {8'h0, rd_a_data}, {8'h0, m_reg[rd_a_sel]});
        chk("R2 R3 R6 R10 port B", {8'h0, rd_b_data}, {8'h0, m_reg[rd_b_sel]});
        chk("R4 R5 X", ptr_x, mptr(26));
        chk("R4 R5 Y", ptr_y, mptr(28));
        chk("R4 R5 Z", ptr_z, mptr(30));
        chk("R4 const", const_addr, mptr(30));
        exp_rd = 8'h00;
        if (ds_re) begin
            if (a < 32)       exp_rd = m_reg[a];
            else if (a < 96)  exp_rd = m_io[a-32];
            else if (a < 224) exp_rd = m_ram[a-96];
        end
        chk(a < 32 ? "R6 read" : a < 96 ? "R7 read" : a < 224 ? "R8 read" : "R9 read",
            {8'h0, ds_rdata}, {8'h0, exp_rd});
        chk("R7 R9 io_we", {15'h0, io_we}, {15'h0, ds_we && a >= 32 && a < 96});
        chk("R7 R9 io_re", {15'h0, io_re}, {15'h0, ds_re && a >= 32 && a < 96});
        if (io_we || io_re) chk("R7 io_addr", {10'h0, io_addr}, 16'(a - 32));
        if (io_we) chk("R7 io_wdata", {8'h0, io_wdata}, {8'h0, ds_wdata});
        // Model update with ALU > pointer > data-space priority.
        nreg = m_reg;
        if (!rst_n) begin
            foreach (nreg[i]) nreg[i] = 8'h00;
            foreach (m_ram[i]) m_ram[i] = 8'h00;
        end else begin
            if (ds_we && a < 32) nreg[a] = ds_wdata;
            if (ds_we && a >= 32 && a < 96) m_io[a-32] = ds_wdata;
            if (ds_we && a >= 96 && a < 224) m_ram[a-96] = ds_wdata;
            if (ptr_sel != 2'd3 && (ptr_op == 2'd1 || ptr_op == 2'd2)) begin
                int lo;
                logic [15:0] p;
                lo = 26 + 2 * int'(ptr_sel);
                p  = mptr(lo);
                p  = (ptr_op == 2'd1) ? p + 16'd1 : p - 16'd1;
                nreg[lo]   = p[7:0];
                nreg[lo+1] = p[15:8];
            end
            if (alu_we) nreg[alu_wsel] = alu_wdata;
        end
        m_reg = nreg;
        @(negedge clk);
    endtask

    task automatic idle();
        alu_we = 0; ds_we = 0; ds_re = 0; ptr_sel = 2'd3; ptr_op = 2'd0;
    endtask

    task automatic ds_wr(logic [7:0] a, logic [7:0] d);
        idle(); ds_we = 1; ds_addr = a; ds_wdata = d; cyc();
    endtask

    initial begin
        foreach (m_reg[i]) m_reg[i] = 8'h00;
        foreach (m_ram[i]) m_ram[i] = 8'h00;
        foreach (m_io[i])  m_io[i]  = 8'(i * 3 + 1);
        rst_n = 0; idle(); rd_a_sel = 0; rd_b_sel = 0; alu_wsel = 0; alu_wdata = 0;
        ds_addr = 0; ds_wdata = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: everything cleared after reset.
        for (int i = 0; i < 32; i++) begin
            rd_a_sel = 5'(i); rd_b_sel = 5'(31 - i); ds_re = 1; ds_addr = 8'(96 + i * 4);
            #1 chk("R1 reg", {8'h0, rd_a_data}, 16'h0);
            chk("R1 ram", {8'h0, ds_rdata}, 16'h0);
            cyc();
        end
        chk("R1 ptr", ptr_z, 16'h0);
        // R6 then R5 carry: X = 0x00FF, post-increment gives 0x0100.
        ds_wr(8'h1A, 8'hFF); ds_wr(8'h1B, 8'h00);
        idle(); ptr_sel = 2'd0; ptr_op = 2'd1; cyc();
        idle(); #1 chk("R5 carry", ptr_x, 16'h0100); cyc();
        // R5 borrow: Z from 0x0000 pre-decrements to 0xFFFF.
        idle(); ptr_sel = 2'd2; ptr_op = 2'd2; cyc();
        idle(); #1 chk("R5 borrow", const_addr, 16'hFFFF); cyc();
        // R10: ALU and data-space hit register 5 together.
        idle(); alu_we = 1; alu_wsel = 5; alu_wdata = 8'hAA; ds_we = 1; ds_addr = 8'h05;
        ds_wdata = 8'h55; cyc();
        idle(); rd_a_sel = 5; #1 chk("R10 alu over ds", {8'h0, rd_a_data}, 16'h00AA); cyc();
        // R10: pointer update over data-space on r28, ALU over pointer on r29.
        idle(); ptr_sel = 2'd1; ptr_op = 2'd1; ds_we = 1; ds_addr = 8'h1C; ds_wdata = 8'h77;
        alu_we = 1; alu_wsel = 29; alu_wdata = 8'h42; cyc();
        idle(); #1 chk("R10 pointer priority", ptr_y, 16'h4201); cyc();
        // R2: same-cycle read returns the old value.
        idle(); alu_we = 1; alu_wsel = 7; alu_wdata = 8'h3C; rd_b_sel = 7;
        #1 chk("R2 old value", {8'h0, rd_b_data}, 16'h0000); cyc();
        idle(); #1 chk("R2 new value", {8'h0, rd_b_data}, 16'h003C); cyc();
        // R7: window edges.
        idle(); ds_we = 1; ds_addr = 8'h20; ds_wdata = 8'h11;
        #1 chk("R7 low edge", {9'h0, io_we, io_addr}, 16'h0040); cyc();
        idle(); ds_re = 1; ds_addr = 8'h5F;
        #1 chk("R7 high edge", {9'h0, io_re, io_addr}, 16'h007F); cyc();
        // R8: SRAM edges.
        ds_wr(8'h60, 8'hC1); ds_wr(8'hDF, 8'hC2);
        idle(); ds_re = 1; ds_addr = 8'h60; #1 chk("R8 first", {8'h0, ds_rdata}, 16'h00C1); cyc();
        idle(); ds_re = 1; ds_addr = 8'hDF; #1 chk("R8 last", {8'h0, ds_rdata}, 16'h00C2); cyc();
        // R9: unmapped writes leave neighbours untouched and read zero.
        idle(); ds_we = 1; ds_addr = 8'hE0; ds_wdata = 8'h99;
        #1 chk("R9 no strobe", {15'h0, io_we}, 16'h0); cyc();
        ds_wr(8'hFF, 8'h98);
        idle(); ds_re = 1; ds_addr = 8'hE0; #1 chk("R9 read zero", {8'h0, ds_rdata}, 16'h0); cyc();
        idle(); ds_re = 1; ds_addr = 8'hDF; #1 chk("R9 ram intact", {8'h0, ds_rdata}, 16'h00C2); cyc();
        // Random traffic, biased toward the pointer registers.
        for (int n = 0; n < 4000; n++) begin
            rd_a_sel  = 5'($urandom);
            rd_b_sel  = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
            alu_we    = ($urandom % 3) == 0;
            alu_wsel  = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
            alu_wdata = 8'($urandom);
            ptr_sel   = 2'($urandom);
            ptr_op    = 2'($urandom);
            ds_re     = $urandom % 2;
            ds_we     = ($urandom % 3) == 0;
            ds_addr   = ($urandom % 3 == 0) ? 8'(26 + $urandom % 6) : 8'($urandom);
            ds_wdata  = 8'($urandom);
            cyc();
        end
        idle();
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule